// File: doc/BRIEF.md
# Spectral Kurtosis Power Accumulator

This block collects, for every frequency channel of a channelized complex stream, the two running sums that a spectral kurtosis estimator needs: the sum of instantaneous power and the sum of squared power. Each accepted input beat carries two channels side by side. The even lane holds channel 2k and the odd lane holds channel 2k+1, where k is the beat's position inside the current spectrum. Each lane carries a signed real and a signed imaginary part.

After a programmable number of spectra, the finished sums are streamed out in ascending channel order over a valid/ready interface. Each output beat is tagged with a running integration number. Two storage banks alternate, so the next integration accumulates while the previous one drains. Both sums saturate rather than wrap. Any saturation raises a sticky overflow flag. The first spectrum of an integration overwrites storage instead of adding to it, so no clear pass is needed between integrations.

Top module: `sk_power_acc`

## Requirements
- R1: Beats with `in_valid_i` high are counted modulo N_CHAN/2 to give the slot k. The even lane updates channel 2k and the odd lane updates channel 2k+1. Inputs presented while `in_valid_i` is low change nothing.
- R2: Instantaneous power is re*re + im*im at full precision (36 bits for 18-bit inputs). P is the 32-bit sum of these powers over the integration and saturates at 2^32-1.
- R3: The P² term is the full 72-bit square of the power, keeping bits 71:8 (a right shift by 8). P² is the 64-bit sum of these terms and saturates at 2^64-1.
- R4: The first spectrum of every integration replaces the stored sums. No value carries over from an earlier integration, including saturated ones.
- R5: `acc_len_i` is sampled on the first beat of each integration and holds for that whole integration. A value of 0 acts as 1. Changes made mid-integration apply only from the next integration.
- R6: Readout starts two clock edges after the final beat of an integration is accepted. It presents channels 0 to N_CHAN-1 in ascending order, with `out_last_o` high on the last one. While `out_valid_o` is high and `out_ready_i` is low, all output fields hold.
- R7: `out_acc_num_o` is a 32-bit number that is 0 for the first integration after reset and rises by 1 for each later one. It stays constant through a readout.
- R8: `ovf_o` rises on the first saturation of either sum in either lane and stays high until reset.
- R9: After reset `out_valid_o` and `ovf_o` are low, and the first integration is numbered 0.
- R10: Accumulation of the next integration proceeds in the other bank while a readout is in progress. The final beat of an integration must not be presented until the previous readout has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input beat valid |
| even_re_i | input | 18 | Even-lane real part, signed |
| even_im_i | input | 18 | Even-lane imaginary part, signed |
| odd_re_i | input | 18 | Odd-lane real part, signed |
| odd_im_i | input | 18 | Odd-lane imaginary part, signed |
| acc_len_i | input | 16 | Spectra per integration, 0 acts as 1 |
| out_valid_o | output | 1 | Readout beat valid |
| out_ready_i | input | 1 | Readout beat accepted |
| out_chan_o | output | 4 | Channel index of readout beat |
| out_p_o | output | 32 | Accumulated power |
| out_p2_o | output | 64 | Accumulated squared power |
| out_acc_num_o | output | 32 | Integration number |
| out_last_o | output | 1 | Final channel of readout |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The bench first applies small random samples with random idle gaps over several overlapping integrations. This separates correct channel-to-lane mapping, correct summation and correct bank alternation from a design that mixes up lanes, wraps the slot count wrongly or reads the bank being written. Integration lengths of 0, 3, 4 and 1 are tried, with the length changed in the middle of an integration. These runs tell correct length sampling apart from a design that reads the length continuously. Full-scale negative samples drive both sums into saturation and set the sticky flag. A normal integration then follows, showing that the overwrite-on-first-spectrum rule clears saturated values while the flag stays set. Random back-pressure on the output checks the hold behaviour and the ascending order.

// File: rtl/sk_pkg.sv
package sk_pkg;
  typedef enum logic {RD_IDLE, RD_BUSY} rd_state_e;
endpackage

// File: rtl/sk_lane_power.sv
module sk_lane_power #(
  parameter int DATA_W = 18,
  parameter int PWR_W  = 2 * DATA_W,
  parameter int P2_W   = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DATA_W-1:0] re_i,
  input  logic signed [DATA_W-1:0] im_i,
  output logic [PWR_W-1:0]         pwr_o,
  output logic [P2_W-1:0]          pwr_sq_o
);
  localparam int SQ_W  = 2 * PWR_W;
  localparam int SHIFT = (SQ_W > P2_W) ? SQ_W - P2_W : 0;
  localparam logic [PWR_W-1:0] PWR_MAX = PWR_W'(1) << (PWR_W - 1);

  logic signed [2*DATA_W-1:0] re_sq, im_sq;
  logic [PWR_W-1:0] pwr;
  logic [SQ_W-1:0]  sq;

  always_comb begin
    re_sq = re_i * re_i;
    im_sq = im_i * im_i;
    pwr   = PWR_W'($unsigned(re_sq)) + PWR_W'($unsigned(im_sq));
    sq    = SQ_W'(pwr) * SQ_W'(pwr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_o    <= '0;
      pwr_sq_o <= '0;
    end else if (en_i) begin
      pwr_o    <= pwr;
      pwr_sq_o <= P2_W'(sq >> SHIFT);
    end
  end

  // power of two squares never exceeds 2 * (2^(DATA_W-1))^2
  assert_pwr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_o <= PWR_MAX);
endmodule

// File: rtl/sk_acc_bank.sv
module sk_acc_bank #(
  parameter int N_SLOT = 8,
  parameter int IDX_W  = 3,
  parameter int PWR_W  = 36,
  parameter int P_W    = 32,
  parameter int P2_W   = 64
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic             wr_bank_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_first_i,
  input  logic [PWR_W-1:0] pwr_i,
  input  logic [P2_W-1:0]  pwr_sq_i,
  input  logic             rd_bank_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [P_W-1:0]   rd_p_o,
  output logic [P2_W-1:0]  rd_p2_o,
  output logic             sat_o
);
  localparam int SP_W = ((PWR_W > P_W) ? PWR_W : P_W) + 1;
  localparam int S2_W = P2_W + 1;
  localparam logic [P_W-1:0]  P_MAX  = '1;
  localparam logic [P2_W-1:0] P2_MAX = '1;

  logic [P_W-1:0]  p_mem  [2][N_SLOT];
  logic [P2_W-1:0] p2_mem [2][N_SLOT];

  logic [P_W-1:0]  base_p, next_p;
  logic [P2_W-1:0] base_p2, next_p2;
  logic [SP_W-1:0] sum_p;
  logic [S2_W-1:0] sum_p2;
  logic            sat_p, sat_p2;

  always_comb begin
    base_p  = wr_first_i ? '0 : p_mem[wr_bank_i][wr_idx_i];
    base_p2 = wr_first_i ? '0 : p2_mem[wr_bank_i][wr_idx_i];
    sum_p   = SP_W'(base_p) + SP_W'(pwr_i);
    sum_p2  = S2_W'(base_p2) + S2_W'(pwr_sq_i);
    sat_p   = sum_p > SP_W'(P_MAX);
    sat_p2  = sum_p2 > S2_W'(P2_MAX);
    next_p  = sat_p  ? P_MAX  : sum_p[P_W-1:0];
    next_p2 = sat_p2 ? P2_MAX : sum_p2[P2_W-1:0];
    sat_o   = wr_en_i && (sat_p || sat_p2);
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      p_mem[wr_bank_i][wr_idx_i]  <= next_p;
      p2_mem[wr_bank_i][wr_idx_i] <= next_p2;
    end
  end

  assign rd_p_o  = p_mem[rd_bank_i][rd_idx_i];
  assign rd_p2_o = p2_mem[rd_bank_i][rd_idx_i];
endmodule

// File: rtl/sk_frame_ctrl.sv
module sk_frame_ctrl #(
  parameter int N_SLOT = 8,
  parameter int IDX_W  = 3,
  parameter int LEN_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [LEN_W-1:0] acc_len_i,
  output logic [IDX_W-1:0] slot_o,
  output logic             first_o,
  output logic             last_o,
  output logic             bank_o
);
  logic [IDX_W-1:0] slot_q;
  logic [LEN_W-1:0] spec_q, len_q, len_raw, len_eff;
  logic             bank_q, start, end_spec;

  always_comb begin
    start    = (slot_q == '0) && (spec_q == '0);
    len_raw  = start ? acc_len_i : len_q;
    len_eff  = (len_raw == '0) ? LEN_W'(1) : len_raw;
    end_spec = slot_q == IDX_W'(N_SLOT - 1);
    last_o   = end_spec && (spec_q == len_eff - LEN_W'(1));
    first_o  = spec_q == '0;
    slot_o   = slot_q;
    bank_o   = bank_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      spec_q <= '0;
      len_q  <= LEN_W'(1);
      bank_q <= 1'b0;
    end else if (valid_i) begin
      if (start) len_q <= len_eff;
      slot_q <= end_spec ? '0 : slot_q + IDX_W'(1);
      if (end_spec) spec_q <= last_o ? '0 : spec_q + LEN_W'(1);
      if (last_o) bank_q <= ~bank_q;
    end
  end

  // an integration's final beat is followed by slot 0 of a fresh first spectrum
  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && last_o |=> slot_o == '0 && first_o);
endmodule

// File: rtl/sk_power_acc.sv
module sk_power_acc import sk_pkg::*; #(
  parameter int N_CHAN = 16,
  parameter int DATA_W = 18,
  parameter int P_W    = 32,
  parameter int P2_W   = 64,
  parameter int LEN_W  = 16,
  parameter int CNT_W  = 32,
  localparam int CH_W  = $clog2(N_CHAN)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] even_re_i,
  input  logic signed [DATA_W-1:0] even_im_i,
  input  logic signed [DATA_W-1:0] odd_re_i,
  input  logic signed [DATA_W-1:0] odd_im_i,
  input  logic [LEN_W-1:0]         acc_len_i,
  output logic                     out_valid_o,
  input  logic                     out_ready_i,
  output logic [CH_W-1:0]          out_chan_o,
  output logic [P_W-1:0]           out_p_o,
  output logic [P2_W-1:0]          out_p2_o,
  output logic [CNT_W-1:0]         out_acc_num_o,
  output logic                     out_last_o,
  output logic                     ovf_o
);
  localparam int N_SLOT = N_CHAN / 2;
  localparam int IDX_W  = CH_W - 1;
  localparam int PWR_W  = 2 * DATA_W;

  logic [IDX_W-1:0] slot, idx1_q;
  logic             first, last, bank;
  logic             v1_q, first1_q, last1_q, bank1_q;

  sk_frame_ctrl #(.N_SLOT(N_SLOT), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni, .valid_i(in_valid_i), .acc_len_i,
    .slot_o(slot), .first_o(first), .last_o(last), .bank_o(bank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0; idx1_q <= '0; first1_q <= 1'b0; last1_q <= 1'b0; bank1_q <= 1'b0;
    end else begin
      v1_q <= in_valid_i;
      if (in_valid_i) begin
        idx1_q <= slot; first1_q <= first; last1_q <= last; bank1_q <= bank;
      end
    end
  end

  logic signed [DATA_W-1:0] re_w [2];
  logic signed [DATA_W-1:0] im_w [2];
  logic [P_W-1:0]  rd_p_w  [2];
  logic [P2_W-1:0] rd_p2_w [2];
  logic [1:0]      sat_w;

  rd_state_e        rd_state_q;
  logic [CH_W-1:0]  rd_chan_q;
  logic             rd_bank_q, ovf_q;
  logic [CNT_W-1:0] int_cnt_q, out_num_q;

  assign re_w[0] = even_re_i;
  assign im_w[0] = even_im_i;
  assign re_w[1] = odd_re_i;
  assign im_w[1] = odd_im_i;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [PWR_W-1:0] pwr;
    logic [P2_W-1:0]  pwr_sq;

    sk_lane_power #(.DATA_W(DATA_W), .PWR_W(PWR_W), .P2_W(P2_W)) u_pwr (
      .clk_i, .rst_ni, .en_i(in_valid_i), .re_i(re_w[l]), .im_i(im_w[l]),
      .pwr_o(pwr), .pwr_sq_o(pwr_sq)
    );

    sk_acc_bank #(.N_SLOT(N_SLOT), .IDX_W(IDX_W), .PWR_W(PWR_W), .P_W(P_W), .P2_W(P2_W)) u_bank (
      .clk_i, .wr_en_i(v1_q), .wr_bank_i(bank1_q), .wr_idx_i(idx1_q), .wr_first_i(first1_q),
      .pwr_i(pwr), .pwr_sq_i(pwr_sq),
      .rd_bank_i(rd_bank_q), .rd_idx_i(rd_chan_q[CH_W-1:1]),
      .rd_p_o(rd_p_w[l]), .rd_p2_o(rd_p2_w[l]), .sat_o(sat_w[l])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_state_q <= RD_IDLE;
      rd_chan_q  <= '0;
      rd_bank_q  <= 1'b0;
      int_cnt_q  <= '0;
      out_num_q  <= '0;
      ovf_q      <= 1'b0;
    end else begin
      ovf_q <= ovf_q | (|sat_w);
      if (v1_q && last1_q) begin
        rd_state_q <= RD_BUSY;
        rd_chan_q  <= '0;
        rd_bank_q  <= bank1_q;
        out_num_q  <= int_cnt_q;
        int_cnt_q  <= int_cnt_q + CNT_W'(1);
      end else if (rd_state_q == RD_BUSY && out_ready_i) begin
        if (rd_chan_q == CH_W'(N_CHAN - 1)) rd_state_q <= RD_IDLE;
        else rd_chan_q <= rd_chan_q + CH_W'(1);
      end
    end
  end

  assign out_valid_o   = rd_state_q == RD_BUSY;
  assign out_chan_o    = rd_chan_q;
  assign out_p_o       = rd_p_w[rd_chan_q[0]];
  assign out_p2_o      = rd_p2_w[rd_chan_q[0]];
  assign out_acc_num_o = out_num_q;
  assign out_last_o    = out_valid_o && (rd_chan_q == CH_W'(N_CHAN - 1));
  assign ovf_o         = ovf_q;

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_chan_o)
      && $stable(out_p_o) && $stable(out_p2_o));
  assert_ascend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !out_last_o |=> out_valid_o
      && out_chan_o == $past(out_chan_o) + CH_W'(1));
  assert_first_chan_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_chan_o == '0);
  assert_num_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && $past(out_valid_o) |-> $stable(out_acc_num_o));
  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: tb/sk_power_acc_test.sv
module sk_power_acc_test;
  localparam int N_CHAN = 16;
  localparam int N_SLOT = N_CHAN / 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic signed [17:0] even_re_i = '0, even_im_i = '0, odd_re_i = '0, odd_im_i = '0;
  logic [15:0] acc_len_i = 16'd3;
  logic out_ready_i = 1'b0;
  logic out_valid_o, out_last_o, ovf_o;
  logic [3:0]  out_chan_o;
  logic [31:0] out_p_o, out_acc_num_o;
  logic [63:0] out_p2_o;

  always #10 clk_i = ~clk_i;

  sk_power_acc uut (.*);

  int n_chk = 0, n_fail = 0;
  bit chk_en = 0, done = 0;

  // behavioural model state
  logic [31:0] m_p  [N_CHAN];
  logic [63:0] m_p2 [N_CHAN];
  int m_slot = 0, m_spec = 0, m_len = 1, m_num = 0;
  bit m_ovf = 0;
  int q_ch[$], q_num[$];
  logic [31:0] q_p[$];
  logic [63:0] q_p2[$];

  function automatic int eff_len(logic [15:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model_lane(int ch, logic signed [17:0] re, logic signed [17:0] im, bit first);
    longint pw;
    logic [71:0] sq;
    logic [63:0] term;
    logic [64:0] s2;
    longint s1;
    pw   = longint'(re) * longint'(re) + longint'(im) * longint'(im);
    sq   = 72'(pw) * 72'(pw);
    term = sq[71:8];
    s1   = (first ? 64'd0 : longint'(m_p[ch])) + pw;
    if (s1 > 64'hFFFF_FFFF) begin m_p[ch] = '1; m_ovf = 1; end
    else m_p[ch] = 32'(s1);
    s2 = (first ? 65'd0 : {1'b0, m_p2[ch]}) + {1'b0, term};
    if (s2[64]) begin m_p2[ch] = '1; m_ovf = 1; end
    else m_p2[ch] = s2[63:0];
  endfunction

  function automatic logic signed [17:0] smp(int mode);
    if (mode == 1) return -18'sd131072;
    return 18'($signed($urandom_range(8191)) - 4096);
  endfunction

  // drive n valid beats with random idle gaps; mode 0 small random, 1 full scale
  task automatic send(int n, int mode);
    for (int b = 0; b < n; b++) begin
      bit start, is_last;
      int len_now;
      while ($urandom_range(4) == 0) begin
        in_valid_i = 1'b0;
        even_re_i = 18'($urandom); odd_im_i = 18'($urandom); // ignored while idle (R1)
        @(negedge clk_i);
      end
      start   = (m_slot == 0) && (m_spec == 0);
      len_now = start ? eff_len(acc_len_i) : m_len;
      is_last = (m_slot == N_SLOT - 1) && (m_spec == len_now - 1);
      if (is_last) begin
        in_valid_i = 1'b0;
        while (out_valid_o) @(negedge clk_i);  // R10 usage rule
      end
      if (start) m_len = len_now;
      in_valid_i = 1'b1;
      even_re_i = smp(mode); even_im_i = smp(mode);
      odd_re_i  = smp(mode); odd_im_i  = smp(mode);
      model_lane(2 * m_slot,     even_re_i, even_im_i, m_spec == 0);
      model_lane(2 * m_slot + 1, odd_re_i,  odd_im_i,  m_spec == 0);
      if (m_slot == N_SLOT - 1) begin
        m_slot = 0;
        if (is_last) begin
          for (int c = 0; c < N_CHAN; c++) begin
            q_ch.push_back(c); q_p.push_back(m_p[c]); q_p2.push_back(m_p2[c]); q_num.push_back(m_num);
          end
          m_num++;
          m_spec = 0;
        end else m_spec++;
      end else m_slot++;
      @(negedge clk_i);
    end
    in_valid_i = 1'b0;
  endtask

  // output comparison on every clock
  always @(negedge clk_i) begin
    if (chk_en) begin
      out_ready_i = ($urandom_range(4) != 0);
      #1;
      if (out_valid_o && q_ch.size() == 0)
        check(0, "R6", "unexpected out_valid", 1, 0);
      else if (out_valid_o && out_ready_i) begin
        check(out_chan_o == 4'(q_ch[0]), "R6", "chan", 64'(out_chan_o), 64'(q_ch[0]));
        check(out_p_o == q_p[0], "R2", "P", 64'(out_p_o), 64'(q_p[0]));
        check(out_p2_o == q_p2[0], "R3", "P2", out_p2_o, q_p2[0]);
        check(out_acc_num_o == 32'(q_num[0]), "R7", "acc num", 64'(out_acc_num_o), 64'(q_num[0]));
        check(out_last_o == (q_ch[0] == N_CHAN - 1), "R6", "last", 64'(out_last_o), 64'(q_ch[0] == N_CHAN - 1));
        void'(q_ch.pop_front()); void'(q_p.pop_front()); void'(q_p2.pop_front()); void'(q_num.pop_front());
      end
    end
  end

  task automatic drain();
    int t = 0;
    while (q_ch.size() != 0 && t < 2000) begin @(negedge clk_i); t++; end
    check(q_ch.size() == 0, "R10", "readout drained", 64'(q_ch.size()), 0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(out_valid_o == 0, "R9", "out_valid after reset", 64'(out_valid_o), 0);
    check(ovf_o == 0, "R9", "ovf after reset", 64'(ovf_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_en = 1;
    // R1 R2 R3 R4 R7 R10: overlapping integrations, length 3
    acc_len_i = 16'd3;
    send(4 * 3 * N_SLOT, 0);
    drain();
    // R5: zero length acts as one
    acc_len_i = 16'd0;
    send(2 * N_SLOT, 0);
    drain();
    // R5: mid-integration change applies only to the next integration
    acc_len_i = 16'd4;
    send(12, 0);
    acc_len_i = 16'd1;
    send(4 * N_SLOT - 12 + N_SLOT, 0);
    drain();
    check(ovf_o == 0, "R8", "no overflow on small data", 64'(ovf_o), 0);
    // R8: full scale saturates both sums
    acc_len_i = 16'd5;
    send(5 * N_SLOT, 1);
    drain();
    check(ovf_o == 1 && m_ovf, "R8", "overflow set", 64'(ovf_o), 1);
    // R4: saturated values do not carry over; flag stays
    acc_len_i = 16'd2;
    send(2 * N_SLOT, 0);
    drain();
    check(ovf_o == 1, "R8", "overflow sticky", 64'(ovf_o), 1);
    done = 1;
    report();
  end
endmodule